// File: doc/BRIEF.md
# Programmable Reference Divider with Bypass

This block divides an oscillator clock by a programmable integer ratio. It produces a one-cycle strobe per division period for a downstream phase/frequency detector. A 15-bit down-counter runs on the rising edge of the oscillator itself. At terminal count it reloads from a pending ratio register, so every period is exactly N oscillator cycles and has no idle cycle between periods. A ratio of 1 skips the counter: the oscillator is sent straight to the strobe output.

A second output lets the division rate be observed. Each period it gives a high pulse that lasts four and a half oscillator cycles. This monitor is gated by an enable bit, and it stays low from power-on until the enable is set. The logic is fully static, so the oscillator may run at any rate down to DC.

Top module: `ref_divider`

## Requirements
- R1: While `por_n` is low, and after it rises, both outputs are low. With the reset ratio of 5, the first strobe is high during the fifth oscillator cycle after release.
- R2: For a ratio N from 5 to 32767, `det_strobe` is high for exactly one full oscillator cycle in every N cycles. The strobes are back to back, with no dead cycle.
- R3: A written ratio of 0, 2, 3 or 4 behaves as ratio 5.
- R4: A ratio written with `ratio_wr` during a period does not change that period. It takes effect from the next reload onward.
- R5: While the active ratio is 1, `det_strobe` follows `clk_osc` level for level. When `mon_en` is high, `mon_pulse` also follows `clk_osc`.
- R6: When `mon_en` is high and the ratio is not 1, `mon_pulse` rises at the same rising edge as `det_strobe`. It falls at the falling edge 4.5 oscillator cycles later.
- R7: While `mon_en` is low, `mon_pulse` is low.
- R8: The maximum ratio, 32767 (all 15 bits set), divides correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator input; rising edges advance the counter |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ratio_in | input | 15 | Divide ratio value to be written |
| ratio_wr | input | 1 | Captures `ratio_in` into the pending ratio at a rising edge |
| mon_en | input | 1 | Enables the monitor output |
| det_strobe | output | 1 | Detector strobe, one cycle per period, or the oscillator itself when the ratio is 1 |
| mon_pulse | output | 1 | Gated monitor pulse, 4.5 oscillator cycles wide |

## Verification
A wrong counter value shows up on `det_strobe` at the next terminal count. The strobe arrives early or late by exactly the error, so it becomes visible within one period of at most N cycles. A reload that takes the wrong ratio, or takes it at the wrong moment, shifts every following strobe, and this appears at the first strobe after the write. An error in the monitor timing logic appears within one period as a pulse edge that lands half a cycle off. The bench compares both outputs after every rising and every falling edge, so each of these errors is caught at the first half-cycle where it shows.

// File: rtl/ref_divider.sv
module ref_divider #(
  parameter int W         = 15,
  parameter int MIN_RATIO = 5,
  parameter int PULSE_CYC = 4
) (
  input  logic         clk_osc,
  input  logic         por_n,
  input  logic [W-1:0] ratio_in,
  input  logic         ratio_wr,
  input  logic         mon_en,
  output logic         det_strobe,
  output logic         mon_pulse
);

  localparam logic [W-1:0] MIN_R = W'(MIN_RATIO);
  localparam logic [W-1:0] ONE   = W'(1);
  localparam int           PW    = $clog2(PULSE_CYC + 1);
  localparam logic [PW-1:0] PSET = PW'(PULSE_CYC);

  logic [W-1:0]  pend_q, act_q, cnt_q;
  logic [PW-1:0] hold_q;
  logic          fall_q;
  logic          bypass, at_end, pre_end, mon_raw;
  logic [W-1:0]  ratio_fix;

  assign bypass    = (act_q == ONE);
  assign at_end    = (cnt_q == '0);
  assign pre_end   = (cnt_q == ONE) && !bypass;
  assign ratio_fix = (ratio_in == ONE) ? ONE :
                     (ratio_in < MIN_R) ? MIN_R : ratio_in;

  always_ff @(posedge clk_osc or negedge por_n) begin
    if (!por_n) begin
      pend_q <= MIN_R;
      act_q  <= MIN_R;
      cnt_q  <= MIN_R - ONE;
    end else begin
      if (ratio_wr) pend_q <= ratio_fix;
      if (at_end) begin
        act_q <= pend_q;
        cnt_q <= pend_q - ONE;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk_osc or negedge por_n) begin
    if (!por_n)             hold_q <= '0;
    else if (pre_end)       hold_q <= PSET;
    else if (hold_q != '0)  hold_q <= hold_q - PW'(1);
  end

  always_ff @(negedge clk_osc or negedge por_n) begin
    if (!por_n) fall_q <= 1'b0;
    else        fall_q <= (hold_q != '0);
  end

  assign mon_raw    = bypass ? clk_osc : ((hold_q != '0) || fall_q);
  assign det_strobe = bypass ? clk_osc : at_end;
  assign mon_pulse  = mon_en & mon_raw;

endmodule

// File: rtl/ref_divider_chk.sv
module ref_divider_chk #(
  parameter int W = 15
) (
  input logic         clk_osc,
  input logic         por_n,
  input logic         mon_en,
  input logic         mon_pulse,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] act_q
);

  AST_RELOAD_PERIOD: assert property (@(posedge clk_osc) disable iff (!por_n)
    (cnt_q == '0) |=> (cnt_q == act_q - W'(1))); // R2

  AST_DOWN_STEP: assert property (@(posedge clk_osc) disable iff (!por_n)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1))); // R2

  AST_RATIO_LEGAL: assert property (@(posedge clk_osc) disable iff (!por_n)
    (act_q == W'(1)) || (act_q >= W'(5))); // R3

  AST_CNT_IN_RANGE: assert property (@(posedge clk_osc) disable iff (!por_n)
    (cnt_q < act_q)); // R4

  AST_MON_START: assert property (@(posedge clk_osc) disable iff (!por_n)
    (cnt_q == W'(1) && act_q != W'(1) && mon_en) |=> (mon_pulse || !mon_en)); // R6

  AST_MON_QUIET: assert property (@(posedge clk_osc) disable iff (!por_n)
    (act_q != W'(1) && act_q > W'(6) && cnt_q == W'(1)) |-> (!mon_pulse || !mon_en)); // R7

endmodule

bind ref_divider ref_divider_chk #(.W(W)) u_chk (
  .clk_osc  (clk_osc),
  .por_n    (por_n),
  .mon_en   (mon_en),
  .mon_pulse(mon_pulse),
  .cnt_q    (cnt_q),
  .act_q    (act_q)
);

// File: tb/ref_divider_bench.sv
`timescale 1ns/1ps
module ref_divider_bench;
  logic        clk_osc = 1'b0;
  logic        por_n = 1'b0;
  logic [14:0] ratio_in = '0;
  logic        ratio_wr = 1'b0;
  logic        mon_en = 1'b0;
  logic        det_strobe, mon_pulse;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    finished = 1'b0;

  int m_pend = 5, m_act = 5, m_rem = 4, m_left = 0;

  always #5 clk_osc = ~clk_osc;

  ref_divider u_ref_divider (
    .clk_osc(clk_osc), .por_n(por_n), .ratio_in(ratio_in), .ratio_wr(ratio_wr),
    .mon_en(mon_en), .det_strobe(det_strobe), .mon_pulse(mon_pulse)
  );

  task automatic check(input logic got, input logic exp, input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s at %0t: got %b expected %b", cur_req, what, $time, got, exp);
    end
  endtask

  function automatic int clamp(input int v);
    if (v == 1) return 1;
    if (v < 5) return 5;
    return v;
  endfunction

  always @(posedge clk_osc) begin
    if (!por_n) begin
      m_pend = 5; m_act = 5; m_rem = 4; m_left = 0;
    end else begin
      if (m_left > 0) m_left--;
      if (m_rem == 1 && m_act != 1) m_left = 9;
      if (m_rem == 0) begin
        m_act = m_pend;
        m_rem = m_act - 1;
      end else m_rem--;
      if (ratio_wr) m_pend = clamp(int'(ratio_in));
    end
    #2;
    check(det_strobe, (m_act == 1) ? 1'b1 : (m_rem == 0), "det_strobe high phase");
    check(mon_pulse, mon_en & ((m_act == 1) ? 1'b1 : (m_left > 0)), "mon_pulse high phase");
  end

  always @(negedge clk_osc) begin
    if (por_n && m_left > 0) m_left--;
    #2;
    check(det_strobe, (m_act == 1) ? 1'b0 : (m_rem == 0), "det_strobe low phase");
    check(mon_pulse, mon_en & ((m_act == 1) ? 1'b0 : (m_left > 0)), "mon_pulse low phase");
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk_osc);
  endtask

  task automatic write_ratio(input int v);
    @(negedge clk_osc);
    ratio_in = 15'(v);
    ratio_wr = 1'b1;
    @(negedge clk_osc);
    ratio_wr = 1'b0;
  endtask

  initial begin
    #150_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    mon_en = 1'b1;
    run(4);
    por_n = 1'b1;
    run(25);
    cur_req = "R6";
    run(20);
    cur_req = "R2";
    write_ratio(12);
    run(60);
    write_ratio(6);
    run(30);
    cur_req = "R3";
    write_ratio(3);
    run(30);
    write_ratio(0);
    run(20);
    write_ratio(2);
    run(20);
    cur_req = "R4";
    write_ratio(9);
    run(12);
    write_ratio(20);
    run(3);
    write_ratio(7);
    run(40);
    cur_req = "R7";
    mon_en = 1'b0;
    run(40);
    cur_req = "R5";
    mon_en = 1'b1;
    write_ratio(1);
    run(20);
    mon_en = 1'b0;
    run(6);
    mon_en = 1'b1;
    write_ratio(8);
    run(40);
    cur_req = "R8";
    write_ratio(32767);
    run(66000);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule